// File: doc/BRIEF.md
# Dual Cascadable Programmable Delay Line

A cycle-accurate digital model of two programmable delay channels. Each channel takes a 1-bit stream and returns it after a selectable number of clock cycles. The selectable part of the delay comes from a chain of binary-weighted stages. The largest-weight stage comes first, and each stage is either used or skipped by a 2:1 multiplexer under one bit of the channel's delay code. A short fixed pipeline in front of the chain gives every channel the same minimum latency, whatever its code.

A mode input selects split operation or chained operation. In split operation each input has its own channel and its own output. In chained operation the output of channel 0 drives the input of channel 1, so input 0 sees the sum of both delays and leaves at output 1. Output 0 is then parked. Both outputs come as a true/complement pair.

One active-low enable gates both inputs to zero before they enter the delay chains. The codes and the mode arrive on parallel ports from a separate loader and are registered inside the block.

Top module: `pdly_top`

## Requirements
- R1: A synchronous reset clears every stage register and the configuration registers, so the block starts in split mode with both codes at zero. While reset holds, q0 and q1 are 0 and q0_n and q1_n are 1.
- R2: In split mode (link_mode = 0), a one-cycle pulse on in0 appears on q0, one cycle wide, exactly 2 + code0 clock cycles later.
- R3: In split mode, a one-cycle pulse on in1 appears on q1, one cycle wide, exactly 2 + code1 clock cycles later. This holds whatever code0 is.
- R4: The delay is linear in the code. Code bit k (bit 0 = LSB) adds 2^k cycles. Code 0 gives the bare 2-cycle minimum, and code 511 gives 513 cycles.
- R5: In chained mode (link_mode = 1), a one-cycle pulse on in0 appears on q1 after 4 + code0 + code1 cycles.
- R6: In chained mode, in1 has no effect: a pulse on in1 never reaches q1.
- R7: In chained mode, q0 is held at 0 and q0_n at 1.
- R8: q1_n is always the complement of q1. In split mode, q0_n is the complement of q0.
- R9: While en_n is 1, both inputs are forced to 0 at the chain entry, so pulses applied then never appear. A pulse taken in while en_n was 0 still emerges if en_n rises afterwards.
- R10: A new code or mode applied before a clock edge takes effect from that edge onward. Changing a code does not clear the stage registers, so data stored in a bypassed stage reappears when that stage is selected again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one delay unit is one period |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low enable for both inputs |
| in0 | input | 1 | Data input of channel 0 |
| in1 | input | 1 | Data input of channel 1 (split mode only) |
| link_mode | input | 1 | 0 = split channels, 1 = channel 0 chained into channel 1 |
| code0 | input | CODE_W | Delay code of channel 0 |
| code1 | input | CODE_W | Delay code of channel 1 |
| q0 | output | 1 | Channel 0 output, true |
| q0_n | output | 1 | Channel 0 output, complement |
| q1 | output | 1 | Channel 1 output, true |
| q1_n | output | 1 | Channel 1 output, complement |

## Verification
The bench builds the block with its default parameters: a 9-bit code and a 2-cycle minimum latency. With these values every stage is reachable, including the 256-cycle stage, the all-ones code of 513 cycles and the longest chained path of 1026 cycles, all within a short run. Single-bit codes, mixed patterns and both extremes are measured as exact pulse latencies. A directed sequence switches a code while a pulse sits inside a bypassed stage, which exposes both the one-edge update timing and the rule that stage registers are not flushed.

// File: rtl/pdly_pkg.sv
package pdly_pkg;

    // Routing of the two channels.
    typedef enum logic {
        LINK_SPLIT = 1'b0,
        LINK_CHAIN = 1'b1
    } link_mode_e;

    // True/complement output pair.
    typedef struct packed {
        logic p;
        logic n;
    } diff_t;

    // Delay contributed by the stage steered by code bit k.
    function automatic int stage_weight(input int k);
        return 1 << k;
    endfunction

    // Drive value for a live channel output.
    function automatic diff_t drive_pair(input logic v);
        diff_t d;
        d.p = v;
        d.n = ~v;
        return d;
    endfunction

    // Value of a parked output.
    localparam diff_t PAIR_PARKED = '{p: 1'b0, n: 1'b1};

endpackage

// File: rtl/pdly_stage.sv
module pdly_stage #(
    parameter int LEN = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic use_dly,
    output logic dout
);

    logic [LEN-1:0] sr;

    // The shift register runs whether or not the stage is selected,
    // so bypassing it leaves its contents intact. R10
    generate
        if (LEN == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) sr <= '0;
                else     sr <= {sr[LEN-2:0], din};
            end
        end
    endgenerate

    assign dout = use_dly ? sr[LEN-1] : din;

endmodule

// File: rtl/pdly_channel.sv
module pdly_channel
    import pdly_pkg::*;
#(
    parameter int CODE_W  = 9,
    parameter int MIN_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic [CODE_W-1:0] code,
    output logic              head,
    output logic              dout
);

    localparam int AGE_W = $clog2(MIN_LAT + 1);

    // Fixed minimum latency pipeline.
    logic [MIN_LAT-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[MIN_LAT-2:0], din};
    end

    assign head = pipe[MIN_LAT-1];

    // Binary-weighted stages, heaviest first. link[k+1] feeds stage k.
    logic [CODE_W:0] link;
    assign link[CODE_W] = head;

    generate
        for (genvar k = CODE_W - 1; k >= 0; k--) begin : g_stage
            pdly_stage #(
                .LEN(stage_weight(k))
            ) u_stage (
                .clk    (clk),
                .rst    (rst),
                .din    (link[k+1]),
                .use_dly(code[k]),
                .dout   (link[k])
            );
        end
    endgenerate

    assign dout = link[0];

    // Cycles since reset, saturating: keeps $past inside valid history.
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk) begin
        if (rst)                        age <= '0;
        else if (age != AGE_W'(MIN_LAT)) age <= age + 1'b1;
    end

    AST_MIN_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age == AGE_W'(MIN_LAT)) |-> (head == $past(din, MIN_LAT))); // R2

    AST_ZERO_CODE: assert property (@(posedge clk) disable iff (rst)
        (age == AGE_W'(MIN_LAT) && code == '0) |-> (dout == $past(din, MIN_LAT))); // R4

endmodule

// File: rtl/pdly_top.sv
module pdly_top
    import pdly_pkg::*;
#(
    parameter int CODE_W  = 9,
    parameter int MIN_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_n,
    input  logic              in0,
    input  logic              in1,
    input  logic              link_mode,
    input  logic [CODE_W-1:0] code0,
    input  logic [CODE_W-1:0] code1,
    output logic              q0,
    output logic              q0_n,
    output logic              q1,
    output logic              q1_n
);

    // Configuration registers: a new value acts from the next edge. R10
    logic [CODE_W-1:0] code0_q;
    logic [CODE_W-1:0] code1_q;
    link_mode_e        mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            code0_q <= '0;
            code1_q <= '0;
            mode_q  <= LINK_SPLIT;
        end else begin
            code0_q <= code0;
            code1_q <= code1;
            mode_q  <= link_mode_e'(link_mode);
        end
    end

    // Shared active-low gate at the chain entries. R9
    logic gated0, gated1;
    assign gated0 = in0 & ~en_n;
    assign gated1 = in1 & ~en_n;

    logic ch0_head, ch0_out, ch1_head, ch1_out, ch1_in;

    assign ch1_in = (mode_q == LINK_CHAIN) ? ch0_out : gated1;

    pdly_channel #(
        .CODE_W (CODE_W),
        .MIN_LAT(MIN_LAT)
    ) u_ch0 (
        .clk (clk),
        .rst (rst),
        .din (gated0),
        .code(code0_q),
        .head(ch0_head),
        .dout(ch0_out)
    );

    pdly_channel #(
        .CODE_W (CODE_W),
        .MIN_LAT(MIN_LAT)
    ) u_ch1 (
        .clk (clk),
        .rst (rst),
        .din (ch1_in),
        .code(code1_q),
        .head(ch1_head),
        .dout(ch1_out)
    );

    diff_t pair0, pair1;
    assign pair0 = (mode_q == LINK_CHAIN) ? PAIR_PARKED : drive_pair(ch0_out);
    assign pair1 = drive_pair(ch1_out);

    assign q0   = pair0.p;
    assign q0_n = pair0.n;
    assign q1   = pair1.p;
    assign q1_n = pair1.n;

    // Cycles since reset, saturating at 2.
    logic [1:0] age;
    always_ff @(posedge clk) begin
        if (rst)             age <= '0;
        else if (age != 2'd2) age <= age + 1'b1;
    end

    AST_CHAIN_PARKS_Q0: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LINK_CHAIN) |-> (!q0 && q0_n)); // R7

    AST_GATE_CH0: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && MIN_LAT == 2 && $past(en_n, 2)) |-> !ch0_head); // R9

    AST_GATE_CH1: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd2 && MIN_LAT == 2 && $past(en_n, 2) && $past(mode_q, 2) == LINK_SPLIT)
        |-> !ch1_head); // R9

    AST_SPLIT_Q0_LIVE: assert property (@(posedge clk) disable iff (rst)
        (mode_q == LINK_SPLIT) |-> (q0 == ch0_out)); // R2

endmodule

// File: tb/sim_pdly_top.sv
module sim_pdly_top;

    localparam int CW     = 9;
    localparam int WINDOW = 1100;
    localparam int NVEC   = 12;

    logic clk = 1'b0;
    logic rst, en_n, in0, in1, link_mode;
    logic [CW-1:0] code0, code1;
    logic q0, q0_n, q1, q1_n;

    always #2 clk = ~clk;

    pdly_top #(.CODE_W(CW), .MIN_LAT(2)) u0 (
        .clk(clk), .rst(rst), .en_n(en_n), .in0(in0), .in1(in1),
        .link_mode(link_mode), .code0(code0), .code1(code1),
        .q0(q0), .q0_n(q0_n), .q1(q1), .q1_n(q1_n)
    );

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    // {mode, code0, code1, src, dst, expected latency}
    localparam logic [31:0] VEC [0:NVEC-1] = '{
        {1'b0, 9'd0,   9'd0,   1'b0, 1'b0, 11'd2},
        {1'b0, 9'd1,   9'd0,   1'b0, 1'b0, 11'd3},
        {1'b0, 9'd256, 9'd0,   1'b0, 1'b0, 11'd258},
        {1'b0, 9'd511, 9'd0,   1'b0, 1'b0, 11'd513},
        {1'b0, 9'd170, 9'd0,   1'b0, 1'b0, 11'd172},
        {1'b0, 9'd5,   9'd200, 1'b0, 1'b0, 11'd7},
        {1'b0, 9'd0,   9'd0,   1'b1, 1'b1, 11'd2},
        {1'b0, 9'd5,   9'd85,  1'b1, 1'b1, 11'd87},
        {1'b0, 9'd0,   9'd511, 1'b1, 1'b1, 11'd513},
        {1'b1, 9'd0,   9'd0,   1'b0, 1'b1, 11'd4},
        {1'b1, 9'd3,   9'd300, 1'b0, 1'b1, 11'd307},
        {1'b1, 9'd511, 9'd511, 1'b0, 1'b1, 11'd1026}
    };

    task automatic chk(input string what, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_cfg(input logic m, input logic [CW-1:0] c0, input logic [CW-1:0] c1);
        link_mode = m;
        code0     = c0;
        code1     = c1;
        repeat (WINDOW) tick();
    endtask

    // Send a one-cycle pulse and watch one output for the whole window.
    task automatic fire(input bit src, input bit dst, input bit raise_en,
                        output int lat, output int width,
                        output int cmp_bad, output int park_bad);
        lat = -1; width = 0; cmp_bad = 0; park_bad = 0;
        if (src) in1 = 1'b1; else in0 = 1'b1;
        for (int k = 1; k <= WINDOW; k++) begin
            tick();
            if (k == 1) begin
                in0 = 1'b0;
                in1 = 1'b0;
                if (raise_en) en_n = 1'b1;
            end
            if ((dst ? q1 : q0) === 1'b1) begin
                if (lat < 0) lat = k;
                width++;
            end
            if (q1_n !== ~q1) cmp_bad++;
            if (!link_mode && q0_n !== ~q0) cmp_bad++;
            if (link_mode && (q0 !== 1'b0 || q0_n !== 1'b1)) park_bad++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int lat, width, cmp_bad, park_bad;
        rst = 1'b1; en_n = 1'b0; in0 = 1'b0; in1 = 1'b0;
        link_mode = 1'b0; code0 = '0; code1 = '0;
        repeat (3) tick();
        // R1: outputs during reset
        chk("R1 q0 in reset", q0, 0);
        chk("R1 q0_n in reset", q0_n, 1);
        chk("R1 q1 in reset", q1, 0);
        chk("R1 q1_n in reset", q1_n, 1);
        rst = 1'b0;
        tick();
        // R1: defaults are split mode, code 0
        fire(1'b0, 1'b0, 1'b0, lat, width, cmp_bad, park_bad);
        chk("R1 default ch0 latency", lat, 2);
        fire(1'b1, 1'b1, 1'b0, lat, width, cmp_bad, park_bad);
        chk("R1 default ch1 latency", lat, 2);

        // Vector table: R2 R3 R4 split latencies, R5 chained, R7, R8
        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] v;
            v = VEC[i];
            set_cfg(v[31], v[30:22], v[21:13]);
            fire(v[12], v[11], 1'b0, lat, width, cmp_bad, park_bad);
            if (v[31]) chk($sformatf("R5 chained latency vec %0d", i), lat, int'(v[10:0]));
            else if (v[11]) chk($sformatf("R3 R4 ch1 latency vec %0d", i), lat, int'(v[10:0]));
            else chk($sformatf("R2 R4 ch0 latency vec %0d", i), lat, int'(v[10:0]));
            chk($sformatf("R2 R3 pulse width vec %0d", i), width, 1);
            chk($sformatf("R8 complement vec %0d", i), cmp_bad, 0);
            if (v[31]) chk($sformatf("R7 q0 parked vec %0d", i), park_bad, 0);
        end

        // R6: in1 ignored in chained mode
        set_cfg(1'b1, 9'd2, 9'd3);
        fire(1'b1, 1'b1, 1'b0, lat, width, cmp_bad, park_bad);
        chk("R6 in1 ignored when chained", width, 0);
        chk("R7 q0 parked during in1 pulse", park_bad, 0);

        // R9: disabled inputs never enter
        en_n = 1'b1;
        set_cfg(1'b0, 9'd3, 9'd4);
        fire(1'b0, 1'b0, 1'b0, lat, width, cmp_bad, park_bad);
        chk("R9 in0 blocked", width, 0);
        fire(1'b1, 1'b1, 1'b0, lat, width, cmp_bad, park_bad);
        chk("R9 in1 blocked", width, 0);
        // R9: pulse taken before disable still emerges
        en_n = 1'b0;
        fire(1'b0, 1'b0, 1'b1, lat, width, cmp_bad, park_bad);
        chk("R9 captured pulse survives disable", lat, 5);
        en_n = 1'b0;

        // R10: code change acts next edge, stage data kept
        set_cfg(1'b0, 9'd2, 9'd0);
        in0 = 1'b1;
        tick();
        in0 = 1'b0;
        tick();
        code0 = 9'd0;
        tick();
        chk("R10 bypass after code 0", q0, 0);
        code0 = 9'd2;
        tick();
        chk("R10 stored pulse reappears", q0, 1);
        tick();
        chk("R10 pulse ends", q0, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule